// File: doc/BRIEF.md
# Two-TAP JTAG Scan Chain with Debug Access Registers

This block puts two JTAG test access ports in series on one TCK/TMS/TDI/TDO/nTRST set. The first TAP after TDI is a boundary-scan TAP with a 5-bit instruction register. It has only a bypass bit and a 32-bit identification register; no boundary cells are modelled. The TAP next to TDO is a debug TAP with a 4-bit instruction register. It holds a bypass bit, a 32-bit identification register and three 35-bit scan registers: debug-port access, access-port access and abort. One 16-state controller drives both TAPs, so they always sit in the same controller state. An IR scan therefore spans 9 bits. A data scan spans the sum of the two selected register lengths.

A debug-port or access-port access scan turns into a one-cycle parallel request when the controller passes Update-DR. The request carries 32 bits of write data, a 2-bit register address, a read flag and a port flag. An outside responder, which in the bench is a stub that answers OK or WAIT, returns read data and a wait flag. The TAP loads these into the same register on the next Capture-DR. Behind the parallel port, the debug-port register map decodes address 01 as control/status, 10 as the port/bank select register (port number in data bits 31:24, bank in bits 7:4) and 11 as the read buffer.

Controller states: Test-Logic-Reset, Run-Test/Idle, Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR, Update-IR. The transitions follow the standard JTAG graph and are taken on each rising TCK edge under TMS. From Test-Logic-Reset, TMS=0 leads to Run-Test/Idle. From Run-Test/Idle, TMS=1 leads to Select-DR. From Select-DR, TMS=1 leads to Select-IR and TMS=0 leads to Capture-DR. From Select-IR, TMS=1 leads to Test-Logic-Reset and TMS=0 leads to Capture-IR. From Capture, TMS=0 leads to Shift and TMS=1 to Exit1. Shift stays in Shift while TMS=0 and goes to Exit1 on TMS=1. From Exit1, TMS=1 leads to Update and TMS=0 to Pause. Pause stays in Pause while TMS=0 and goes to Exit2 on TMS=1. From Exit2, TMS=1 leads to Update and TMS=0 back to Shift. From Update, TMS=1 leads to Select-DR and TMS=0 to Run-Test/Idle.

Top module: `dual_tap_chain`

## Requirements
- R1: Asserting nTRST low, or holding TMS high for five TCK cycles, selects the identification instruction in both TAPs: debug code 1110 and boundary code 00001. A following 64-bit data scan returns the debug ID 0x3BA00477 in its first 32 bits out and the boundary ID in the next 32 bits.
- R2: An IR scan spans 9 bits. The first 4 bits shifted in land in the debug IR (LSB first) and the last 5 land in the boundary IR. Capture-IR loads 0001 and 00001 (binary, LSB being 1), so the first 9 bits out read 1,0,0,0,1,0,0,0,0.
- R3: A TAP in bypass (debug 1111, boundary 11111) adds exactly one bit to the data scan, and that bit captures 0.
- R4: With debug instruction 1110 the debug TAP shifts out 0x3BA00477 LSB first.
- R5: With debug instruction 1010, passing Update-DR raises req_valid for exactly one TCK cycle with req_ap=0. req_wdata, req_addr and req_rnw come from scan bits 34:3, 2:1 and 0 (1 = read), and they hold steady afterwards.
- R6: With debug instruction 1011 the request is the same, but req_ap=1.
- R7: Capture-DR under instruction 1010 or 1011 loads rsp_rdata into bits 34:3. It loads the acknowledge into bits 2:0: 010 (OK) when rsp_wait is 0 and 001 (WAIT) when rsp_wait is 1.
- R8: With debug instruction 1000, passing Update-DR pulses dp_abort for one cycle exactly when scan bit 3 (data bit 0) is 1, and never raises req_valid.
- R9: Any debug instruction other than 1111, 1110, 1010, 1011 or 1000 acts as bypass (one bit capturing 0).
- R10: TDO is 0 in every controller state other than Shift-DR and Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state moves on its rising edge |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data into the boundary TAP |
| tdo | output | 1 | Serial data out of the debug TAP |
| req_valid | output | 1 | One-cycle access request strobe |
| req_ap | output | 1 | 1 = access-port request, 0 = debug-port request |
| req_rnw | output | 1 | 1 = read, 0 = write |
| req_addr | output | 2 | Register address A[3:2] |
| req_wdata | output | 32 | Write data |
| rsp_wait | input | 1 | Responder busy; captured as WAIT acknowledge |
| rsp_rdata | input | 32 | Responder read data |
| dp_abort | output | 1 | One-cycle abort strobe |

## Verification
The bench builds the block with its default parameters: a 4-bit debug IR, a 5-bit boundary IR and 35-bit access registers. This makes the full 64-bit identification chain, the 2-bit all-bypass chain and the 36-bit access chain short enough to scan many times. A behavioural model that tracks the controller and the chain as a bit queue predicts TDO, both strobes and the request fields on every clock. The scenarios reach both acknowledges, the abort bit set and clear, an unlisted debug instruction, and both ways into Test-Logic-Reset.

// File: rtl/dtap_pkg.sv
package dtap_pkg;
    parameter int DBG_IR_W = 4;
    parameter int BSC_IR_W = 5;
    parameter int ID_W     = 32;
    parameter int ACC_W    = 35;
    localparam int ACK_W   = 3;

    localparam logic [DBG_IR_W-1:0] DBG_BYPASS = 4'b1111;
    localparam logic [DBG_IR_W-1:0] DBG_IDCODE = 4'b1110;
    localparam logic [DBG_IR_W-1:0] DBG_DPACC  = 4'b1010;
    localparam logic [DBG_IR_W-1:0] DBG_APACC  = 4'b1011;
    localparam logic [DBG_IR_W-1:0] DBG_ABORT  = 4'b1000;
    localparam logic [BSC_IR_W-1:0] BSC_IDCODE = 5'b00001;

    localparam logic [ACK_W-1:0] ACK_OK   = 3'b010;
    localparam logic [ACK_W-1:0] ACK_WAIT = 3'b001;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    typedef enum logic [2:0] {SEL_BYP, SEL_ID, SEL_DPA, SEL_APA, SEL_ABT} dbg_sel_t;

    typedef struct packed {
        logic tlr;
        logic cap_ir;
        logic shf_ir;
        logic upd_ir;
        logic cap_dr;
        logic shf_dr;
        logic upd_dr;
    } tap_ctl_t;
endpackage

// File: rtl/tap_ctrl_fsm.sv
module tap_ctrl_fsm
    import dtap_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tms,
    output tap_ctl_t ctl
);
    tap_state_t state, state_nx;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TS_RESET:  state_nx = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   state_nx = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: state_nx = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: state_nx = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: state_nx = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: state_nx = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: state_nx = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: state_nx = tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: state_nx = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: state_nx = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: state_nx = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: state_nx = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: state_nx = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: state_nx = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: state_nx = tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: state_nx = tms ? TS_SEL_DR : TS_IDLE;
            default:   state_nx = TS_RESET;
        endcase
    end

    always_comb begin
        ctl        = '0;
        ctl.tlr    = (state == TS_RESET);
        ctl.cap_ir = (state == TS_CAP_IR);
        ctl.shf_ir = (state == TS_SHF_IR);
        ctl.upd_ir = (state == TS_UPD_IR);
        ctl.cap_dr = (state == TS_CAP_DR);
        ctl.shf_dr = (state == TS_SHF_DR);
        ctl.upd_dr = (state == TS_UPD_DR);
    end
endmodule

// File: rtl/bsc_tap.sv
module bsc_tap
    import dtap_pkg::*;
#(
    parameter logic [ID_W-1:0] BSC_ID = 32'h2D1C_40A5
) (
    input  logic     tck,
    input  logic     trst_n,
    input  tap_ctl_t ctl,
    input  logic     si,
    output logic     so
);
    logic [BSC_IR_W-1:0] ir, ir_sr;
    logic [ID_W-1:0]     dr;
    logic                id_sel;

    assign id_sel = (ir == BSC_IDCODE);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir    <= BSC_IDCODE;
            ir_sr <= '0;
            dr    <= '0;
        end else begin
            if (ctl.tlr)         ir <= BSC_IDCODE;
            else if (ctl.upd_ir) ir <= ir_sr;
            if (ctl.cap_ir)      ir_sr <= {{(BSC_IR_W-1){1'b0}}, 1'b1};
            else if (ctl.shf_ir) ir_sr <= {si, ir_sr[BSC_IR_W-1:1]};
            if (ctl.cap_dr)      dr <= id_sel ? BSC_ID : '0;
            else if (ctl.shf_dr) begin
                if (id_sel) dr    <= {si, dr[ID_W-1:1]};
                else        dr[0] <= si;
            end
        end
    end

    assign so = ctl.shf_ir ? ir_sr[0] : dr[0];
endmodule

// File: rtl/dbg_tap.sv
module dbg_tap
    import dtap_pkg::*;
#(
    parameter logic [ID_W-1:0] DBG_ID = 32'h3BA0_0477
) (
    input  logic              tck,
    input  logic              trst_n,
    input  tap_ctl_t          ctl,
    input  logic              si,
    output logic              so,
    input  logic              rsp_wait,
    input  logic [ID_W-1:0]   rsp_rdata,
    output logic              req_valid,
    output logic              req_ap,
    output logic              req_rnw,
    output logic [1:0]        req_addr,
    output logic [ID_W-1:0]   req_wdata,
    output logic              dp_abort
);
    logic [DBG_IR_W-1:0] ir, ir_sr;
    logic [ACC_W-1:0]    dr;
    dbg_sel_t            sel;

    always_comb begin
        case (ir)
            DBG_IDCODE: sel = SEL_ID;
            DBG_DPACC:  sel = SEL_DPA;
            DBG_APACC:  sel = SEL_APA;
            DBG_ABORT:  sel = SEL_ABT;
            default:    sel = SEL_BYP;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir        <= DBG_IDCODE;
            ir_sr     <= '0;
            dr        <= '0;
            req_valid <= 1'b0;
            req_ap    <= 1'b0;
            req_rnw   <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            dp_abort  <= 1'b0;
        end else begin
            req_valid <= 1'b0;
            dp_abort  <= 1'b0;
            if (ctl.tlr)         ir <= DBG_IDCODE;
            else if (ctl.upd_ir) ir <= ir_sr;
            if (ctl.cap_ir)      ir_sr <= {{(DBG_IR_W-1){1'b0}}, 1'b1};
            else if (ctl.shf_ir) ir_sr <= {si, ir_sr[DBG_IR_W-1:1]};
            if (ctl.cap_dr) begin
                unique case (sel)
                    SEL_ID:           dr <= {{(ACC_W-ID_W){1'b0}}, DBG_ID};
                    SEL_DPA, SEL_APA: dr <= {rsp_rdata, rsp_wait ? ACK_WAIT : ACK_OK};
                    default:          dr <= '0;
                endcase
            end else if (ctl.shf_dr) begin
                unique case (sel)
                    SEL_ID:                    dr[ID_W-1:0] <= {si, dr[ID_W-1:1]};
                    SEL_DPA, SEL_APA, SEL_ABT: dr <= {si, dr[ACC_W-1:1]};
                    default:                   dr[0] <= si;
                endcase
            end
            if (ctl.upd_dr) begin
                if (sel == SEL_DPA || sel == SEL_APA) begin
                    req_valid <= 1'b1;
                    req_ap    <= (sel == SEL_APA);
                    req_wdata <= dr[ACC_W-1:ACK_W];
                    req_addr  <= dr[2:1];
                    req_rnw   <= dr[0];
                end
                if (sel == SEL_ABT) dp_abort <= dr[ACK_W];
            end
        end
    end

    assign so = ctl.shf_ir ? ir_sr[0] : dr[0];
endmodule

// File: rtl/dual_tap_chain.sv
module dual_tap_chain
    import dtap_pkg::*;
#(
    parameter logic [ID_W-1:0] DBG_ID = 32'h3BA0_0477,
    parameter logic [ID_W-1:0] BSC_ID = 32'h2D1C_40A5
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            req_valid,
    output logic            req_ap,
    output logic            req_rnw,
    output logic [1:0]      req_addr,
    output logic [ID_W-1:0] req_wdata,
    input  logic            rsp_wait,
    input  logic [ID_W-1:0] rsp_rdata,
    output logic            dp_abort
);
    tap_ctl_t ctl;
    logic     mid;
    logic     dbg_so;

    tap_ctrl_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .ctl(ctl));

    bsc_tap #(.BSC_ID(BSC_ID)) u_bsc (
        .tck(tck), .trst_n(trst_n), .ctl(ctl), .si(tdi), .so(mid)
    );

    dbg_tap #(.DBG_ID(DBG_ID)) u_dbg (
        .tck(tck), .trst_n(trst_n), .ctl(ctl), .si(mid), .so(dbg_so),
        .rsp_wait(rsp_wait), .rsp_rdata(rsp_rdata),
        .req_valid(req_valid), .req_ap(req_ap), .req_rnw(req_rnw),
        .req_addr(req_addr), .req_wdata(req_wdata), .dp_abort(dp_abort)
    );

    assign tdo = (ctl.shf_ir || ctl.shf_dr) ? dbg_so : 1'b0;
endmodule

// File: rtl/dual_tap_chain_chk.sv
module dual_tap_chain_chk
    import dtap_pkg::*;
(
    input logic                tck,
    input logic                trst_n,
    input tap_state_t          st,
    input logic [DBG_IR_W-1:0] dbg_ir,
    input logic [BSC_IR_W-1:0] bsc_ir,
    input logic                req_valid,
    input logic                req_ap,
    input logic                req_rnw,
    input logic [1:0]          req_addr,
    input logic [ID_W-1:0]     req_wdata,
    input logic                dp_abort
);
    a_r1_reset_selects_id: assert property (@(posedge tck) disable iff (!trst_n)
        (st == TS_RESET) |=> (dbg_ir == DBG_IDCODE && bsc_ir == BSC_IDCODE));

    a_r5_req_one_cycle: assert property (@(posedge tck) disable iff (!trst_n)
        req_valid |=> !req_valid);

    a_r5_req_after_update: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(req_valid) |-> $past(st == TS_UPD_DR));

    a_r5_fields_hold: assert property (@(posedge tck) disable iff (!trst_n)
        req_valid |=> ($stable(req_wdata) && $stable(req_addr) && $stable(req_rnw) && $stable(req_ap)));

    a_r8_abort_no_req: assert property (@(posedge tck) disable iff (!trst_n)
        dp_abort |-> !req_valid);

    a_r8_abort_one_cycle: assert property (@(posedge tck) disable iff (!trst_n)
        dp_abort |=> !dp_abort);
endmodule

bind dual_tap_chain dual_tap_chain_chk u_chk (
    .tck(tck), .trst_n(trst_n), .st(u_fsm.state),
    .dbg_ir(u_dbg.ir), .bsc_ir(u_bsc.ir),
    .req_valid(req_valid), .req_ap(req_ap), .req_rnw(req_rnw),
    .req_addr(req_addr), .req_wdata(req_wdata), .dp_abort(dp_abort)
);

// File: tb/dual_tap_chain_tb.sv
module dual_tap_chain_tb_top;
    localparam logic [31:0] DID = 32'h3BA0_0477;
    localparam logic [31:0] BID = 32'h2D1C_40A5;
    localparam int TLR=0, IDLE=1, SDR=2, CDR=3, SHDR=4, E1DR=5, PDR=6, E2DR=7, UDR=8,
                   SIR=9, CIR=10, SHIR=11, E1IR=12, PIR=13, E2IR=14, UIR=15;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, req_valid, req_ap, req_rnw, dp_abort;
    logic [1:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_wait = 1'b0;
    logic [31:0] rsp_rdata = '0;

    int total = 0, bad = 0;
    string cur = "R10";

    always #4 tck = ~tck;

    dual_tap_chain #(.DBG_ID(DID), .BSC_ID(BID)) dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .req_valid(req_valid), .req_ap(req_ap), .req_rnw(req_rnw),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_wait(rsp_wait), .rsp_rdata(rsp_rdata), .dp_abort(dp_abort)
    );

    // behavioural reference model
    int ms;
    bit q[$];
    bit [3:0] m_dir;
    bit [4:0] m_bir;
    bit e_req, e_ap, e_rnw, e_abort;
    bit [1:0] e_addr;
    bit [31:0] e_wd;

    function automatic int nxt(int s, bit m);
        case (s)
            TLR:  return m ? TLR  : IDLE;
            IDLE: return m ? SDR  : IDLE;
            SDR:  return m ? SIR  : CDR;
            CDR, SHDR: return m ? E1DR : SHDR;
            E1DR: return m ? UDR  : PDR;
            PDR:  return m ? E2DR : PDR;
            E2DR: return m ? UDR  : SHDR;
            SIR:  return m ? TLR  : CIR;
            CIR, SHIR: return m ? E1IR : SHIR;
            E1IR: return m ? UIR  : PIR;
            PIR:  return m ? E2IR : PIR;
            E2IR: return m ? UIR  : SHIR;
            default: return m ? SDR : IDLE;
        endcase
    endfunction

    function automatic int dlen(bit [3:0] ir);
        if (ir == 4'b1110) return 32;
        if (ir == 4'b1010 || ir == 4'b1011 || ir == 4'b1000) return 35;
        return 1;
    endfunction

    task automatic model_reset();
        ms = TLR; m_dir = 4'b1110; m_bir = 5'b00001; q = {};
        e_req = 0; e_abort = 0; e_ap = 0; e_rnw = 0; e_addr = 0; e_wd = 0;
    endtask

    task automatic model_step(bit m, bit d);
        bit [34:0] v;
        bit [34:0] cap;
        e_req = 0; e_abort = 0;
        case (ms)
            TLR: begin m_dir = 4'b1110; m_bir = 5'b00001; end
            CIR: begin
                q = {};
                for (int i = 0; i < 4; i++) q.push_back(i == 0);
                for (int i = 0; i < 5; i++) q.push_back(i == 0);
            end
            SHIR, SHDR: begin void'(q.pop_front()); q.push_back(d); end
            UIR: begin
                for (int i = 0; i < 4; i++) m_dir[i] = q[i];
                for (int i = 0; i < 5; i++) m_bir[i] = q[4+i];
            end
            CDR: begin
                q = {};
                cap = '0;
                if (m_dir == 4'b1110) cap = {3'b0, DID};
                else if (m_dir == 4'b1010 || m_dir == 4'b1011)
                    cap = {rsp_rdata, rsp_wait ? 3'b001 : 3'b010};
                for (int i = 0; i < dlen(m_dir); i++) q.push_back(cap[i]);
                if (m_bir == 5'b00001) for (int i = 0; i < 32; i++) q.push_back(BID[i]);
                else q.push_back(1'b0);
            end
            UDR: begin
                v = '0;
                for (int i = 0; i < dlen(m_dir); i++) v[i] = q[i];
                if (m_dir == 4'b1010 || m_dir == 4'b1011) begin
                    e_req = 1; e_ap = (m_dir == 4'b1011);
                    e_wd = v[34:3]; e_addr = v[2:1]; e_rnw = v[0];
                end
                if (m_dir == 4'b1000) e_abort = v[3];
            end
            default: ;
        endcase
        ms = nxt(ms, m);
    endtask

    task automatic chk(string tag, bit ok, logic [69:0] act, logic [69:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one TCK: compare at falling edge, drive, step model
    task automatic clk1(bit m, bit d, output bit o);
        bit et;
        bit ok;
        et = (ms == SHDR || ms == SHIR) ? q[0] : 1'b0;
        o = tdo;
        ok = (tdo === et) && (req_valid === e_req) && (dp_abort === e_abort);
        if (e_req) ok = ok && (req_ap === e_ap) && (req_rnw === e_rnw) &&
                        (req_addr === e_addr) && (req_wdata === e_wd);
        chk({cur, " per-clock"}, ok, {tdo, req_valid, dp_abort}, {et, e_req, e_abort});
        tms = m; tdi = d;
        @(posedge tck);
        model_step(m, d);
        @(negedge tck);
    endtask

    task automatic ir_scan(bit [8:0] v, output bit [8:0] o);
        bit b;
        clk1(1, 0, b); clk1(1, 0, b); clk1(0, 0, b); clk1(0, 0, b);
        for (int i = 0; i < 9; i++) begin clk1(i == 8, v[i], b); o[i] = b; end
        clk1(1, 0, b); clk1(0, 0, b);
    endtask

    task automatic dr_scan(int n, bit [69:0] v, output bit [69:0] o);
        bit b;
        o = '0;
        clk1(1, 0, b); clk1(0, 0, b); clk1(0, 0, b);
        for (int i = 0; i < n; i++) begin clk1(i == n - 1, v[i], b); o[i] = b; end
        clk1(1, 0, b); clk1(0, 0, b);
    endtask

    bit done = 0;
    initial begin
        #1_500_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit [8:0]  io;
        bit [69:0] o;
        bit        b;
        model_reset();
        repeat (3) @(negedge tck);
        chk("R10 reset tdo", tdo === 1'b0, tdo, 0);
        chk("R5 reset req_valid", req_valid === 1'b0, req_valid, 0);
        trst_n = 1'b1;
        clk1(0, 0, b);

        cur = "R1";
        dr_scan(64, '0, o);
        chk("R1 debug id after nTRST", o[31:0] == DID, o[31:0], DID);
        chk("R1 boundary id after nTRST", o[63:32] == BID, o[63:32], BID);

        cur = "R2";
        ir_scan(9'h1FE, io);
        chk("R2 IR capture pattern", io == 9'h011, io, 9'h011);

        cur = "R4";
        dr_scan(33, 70'h1_5555_5555, o);
        chk("R4 debug id", o[31:0] == DID, o[31:0], DID);
        chk("R3 boundary bypass bit", o[32] == 1'b0, o[32], 0);

        cur = "R3";
        ir_scan(9'h1FF, io);
        dr_scan(10, 70'h2D5, o);
        chk("R3 two bypass bits", o[9:0] == {8'hD5, 2'b00}, o[9:0], {8'hD5, 2'b00});

        cur = "R5";
        rsp_wait = 0; rsp_rdata = 32'hCAFE_0123;
        ir_scan(9'h1FA, io);
        dr_scan(36, {35'h0, 32'h1234_5678, 2'b10, 1'b0}, o);
        chk("R5 req strobe", req_valid === 1'b1 && req_ap === 1'b0, {req_valid, req_ap}, 2'b10);
        chk("R5 req fields", req_wdata == 32'h1234_5678 && req_addr == 2'b10 && req_rnw == 1'b0,
            {req_wdata, req_addr, req_rnw}, {32'h1234_5678, 2'b10, 1'b0});

        cur = "R7";
        dr_scan(36, {35'h0, 32'h0, 2'b11, 1'b1}, o);
        chk("R7 OK ack", o[2:0] == 3'b010, o[2:0], 3'b010);
        chk("R7 read data", o[34:3] == 32'hCAFE_0123, o[34:3], 32'hCAFE_0123);
        chk("R5 read request", req_rnw == 1'b1 && req_addr == 2'b11, {req_rnw, req_addr}, 3'b111);
        rsp_wait = 1; rsp_rdata = 32'h0BAD_F00D;
        dr_scan(36, '0, o);
        chk("R7 WAIT ack", o[2:0] == 3'b001, o[2:0], 3'b001);
        chk("R7 wait data", o[34:3] == 32'h0BAD_F00D, o[34:3], 32'h0BAD_F00D);
        rsp_wait = 0;

        cur = "R6";
        ir_scan(9'h1FB, io);
        dr_scan(36, {35'h0, 32'h0000_00F0, 2'b01, 1'b0}, o);
        chk("R6 access-port request", req_valid === 1'b1 && req_ap === 1'b1 && req_wdata == 32'hF0,
            {req_valid, req_ap, req_wdata}, {2'b11, 32'hF0});

        cur = "R8";
        ir_scan(9'h1F8, io);
        dr_scan(36, 70'h8, o);
        chk("R8 abort set", dp_abort === 1'b1 && req_valid === 1'b0, {dp_abort, req_valid}, 2'b10);
        dr_scan(36, 70'h7, o);
        chk("R8 abort clear", dp_abort === 1'b0 && req_valid === 1'b0, {dp_abort, req_valid}, 2'b00);

        cur = "R9";
        ir_scan(9'h1F5, io);
        dr_scan(10, 70'h13C, o);
        chk("R9 unlisted code bypass", o[9:0] == {8'h3C, 2'b00}, o[9:0], {8'h3C, 2'b00});

        cur = "R1";
        for (int i = 0; i < 5; i++) clk1(1, 0, b);
        clk1(0, 0, b);
        dr_scan(64, '0, o);
        chk("R1 debug id after TMS reset", o[31:0] == DID, o[31:0], DID);
        chk("R1 boundary id after TMS reset", o[63:32] == BID, o[63:32], BID);

        cur = "R10";
        clk1(0, 0, b);
        chk("R10 idle tdo", b == 1'b0, b, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule